// File: doc/BRIEF.md
# Serial EEPROM Write Protection and Status Register

This block keeps the status byte of a serial EEPROM and decides, cycle by cycle, whether a write may go ahead. It holds a write-enable latch, a two-bit block-protect level, a pin-lock enable bit and a busy indication. It combines them with the external write-protect pin level to produce two permits: one for the array address offered on `chk_addr`, and one for a status write. The serial front end sends one-cycle command strobes into the block: set latch, clear latch and status write with data. The array write engine reports its own busy level and a done pulse. The nonvolatile bits are plain flops with reset values, and the memory array is outside the block.

An accepted status write starts a program cycle timed inside the block. The cycle lasts `SR_PROG_CYC` clocks, and the new protection bits take effect when it ends. A cycle controller with three named states orders the work. `CYC_IDLE` accepts commands. It moves to `CYC_SR_PROG` on an accepted status write, and to `CYC_ARR_PROG` when the engine raises busy. `CYC_SR_PROG` returns to `CYC_IDLE` when its timer reaches the last count, and commits the pending bits on that edge. `CYC_ARR_PROG` returns to `CYC_IDLE` on the engine's done pulse. Both returns clear the write-enable latch.

Top module: `blkprot_status`

## Requirements
- R1: Outside a write cycle the status byte is {lock-enable bit at bit 7, zeros at bits 6..4, protect level at bits 3..2, write-enable latch at bit 1, 0 at bit 0}.
- R2: While a write cycle runs (the status program timer or `eng_busy` high), the status byte reads 8'hFF.
- R3: The protect level decodes as follows: 2'b00 protects nothing, 2'b01 protects the top quarter of the address space, 2'b10 the top half, and 2'b11 every address. `arr_wr_ok` is 0 for any protected `chk_addr`.
- R4: `arr_wr_ok` is 1 only when the latch is 1, `wp_pin` is high, no cycle runs and the address is unprotected.
- R5: `sr_wr_ok` is 1 only when the latch is 1, no cycle runs, and the lock is not active. The lock is active when `wp_pin` is low and the lock-enable bit is 1.
- R6: The latch is 0 after reset and clears on the edge that ends any write cycle.
- R7: `wel_set` sets the latch only while `wp_pin` is high. `wel_clr` clears it at any pin level, and it wins when both strobes arrive together.
- R8: An accepted status write takes only data bits 7, 3 and 2. It holds the busy view for `SR_PROG_CYC` clocks, then applies those bits.
- R9: While a cycle runs, the set, clear and status-write strobes have no effect and both permits are 0.
- R10: A status write strobe while `sr_wr_ok` is 0 changes no bit and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin | input | 1 | Write-protect pin level, 1 = high |
| wel_set | input | 1 | Strobe: set the write-enable latch |
| wel_clr | input | 1 | Strobe: clear the write-enable latch |
| sr_wr_req | input | 1 | Strobe: status write with `sr_wr_data` |
| sr_wr_data | input | 8 | Status write data |
| chk_addr | input | ADDR_W | Array address whose write permit is asked |
| eng_busy | input | 1 | Array write engine busy level |
| eng_done | input | 1 | Array write engine completion pulse |
| status_byte | output | 8 | Status byte for reads |
| arr_wr_ok | output | 1 | Array write permit for `chk_addr` |
| sr_wr_ok | output | 1 | Status write permit |

## Verification
Two pairs of events can fall in the same cycle. The first is a set strobe and a clear strobe, where the clear must win. The second is the end of a write cycle arriving together with command strobes, where the clear at the end of the cycle must win and the strobes must be dropped. The bench drives both strobes on one clock edge. It also keeps set, clear and status-write strobes going while the array engine raises done. On every clock, a behavioural reference model predicts the status byte and both permits, and the bench compares them with the outputs.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE     = 2'd0,
        CYC_SR_PROG  = 2'd1,
        CYC_ARR_PROG = 2'd2
    } cyc_state_t;

    localparam int SR_W = 8;
    // bits of the status byte that are nonvolatile and writable
    localparam logic [SR_W-1:0] SR_NV_MASK = 8'b1000_1100;
    localparam int BIT_LOCKEN = 7;
    localparam int BIT_LVL_HI = 3;
    localparam int BIT_LVL_LO = 2;
    localparam int BIT_WEL    = 1;
endpackage

// File: rtl/blkprot_range_dec.sv
module blkprot_range_dec #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (level)
            2'b00:   prot = 1'b0;
            2'b01:   prot = addr[TOP] & addr[TOP-1];
            2'b10:   prot = addr[TOP];
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/blkprot_cycle_fsm.sv
module blkprot_cycle_fsm
    import blkprot_pkg::*;
#(
    parameter int SR_PROG_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_start,
    input  logic       eng_busy,
    input  logic       eng_done,
    output logic       cyc_active,
    output logic       cyc_end,
    output logic       sr_commit,
    output cyc_state_t state_o
);
    localparam int TMR_W = (SR_PROG_CYC > 1) ? $clog2(SR_PROG_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SR_PROG_CYC - 1);

    cyc_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_hit;

    assign tmr_hit = (tmr_q == TMR_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: begin
                if (eng_busy)      state_d = CYC_ARR_PROG;
                else if (sr_start) state_d = CYC_SR_PROG;
            end
            CYC_SR_PROG:  if (tmr_hit)  state_d = CYC_IDLE;
            CYC_ARR_PROG: if (eng_done) state_d = CYC_IDLE;
            default:      state_d = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CYC_SR_PROG && !tmr_hit) tmr_q <= tmr_q + 1'b1;
            else                                    tmr_q <= '0;
        end
    end

    always_comb begin
        cyc_active = 1'b0;
        cyc_end    = 1'b0;
        sr_commit  = 1'b0;
        unique case (state_q)
            CYC_IDLE: ;
            CYC_SR_PROG: begin
                cyc_active = 1'b1;
                cyc_end    = tmr_hit;
                sr_commit  = tmr_hit;
            end
            CYC_ARR_PROG: begin
                cyc_active = 1'b1;
                cyc_end    = eng_done;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/blkprot_status.sv
module blkprot_status
    import blkprot_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SR_PROG_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic [7:0]        status_byte,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok
);
    logic [SR_W-1:0] nv_q;
    logic [SR_W-1:0] pend_q;
    logic            wel_q;
    logic            cyc_active, cyc_end, sr_commit;
    logic            busy_all, cmd_ok, lock_on, addr_prot, sr_accept;
    cyc_state_t      cyc_state;

    assign busy_all  = cyc_active | eng_busy;
    assign cmd_ok    = ~busy_all;
    assign lock_on   = nv_q[BIT_LOCKEN] & ~wp_pin;
    assign sr_wr_ok  = cmd_ok & wel_q & ~lock_on;
    assign sr_accept = sr_wr_req & sr_wr_ok;

    blkprot_range_dec #(.ADDR_W(ADDR_W)) u_range (
        .level (nv_q[BIT_LVL_HI:BIT_LVL_LO]),
        .addr  (chk_addr),
        .prot  (addr_prot)
    );

    blkprot_cycle_fsm #(.SR_PROG_CYC(SR_PROG_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_start   (sr_accept),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .cyc_active (cyc_active),
        .cyc_end    (cyc_end),
        .sr_commit  (sr_commit),
        .state_o    (cyc_state)
    );

    assign arr_wr_ok = cmd_ok & wel_q & wp_pin & ~addr_prot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            nv_q   <= '0;
            pend_q <= '0;
        end else begin
            if (cyc_end)                         wel_q <= 1'b0;
            else if (cmd_ok && wel_clr)          wel_q <= 1'b0;
            else if (cmd_ok && wel_set && wp_pin) wel_q <= 1'b1;

            if (sr_accept) pend_q <= sr_wr_data;
            if (sr_commit) nv_q   <= pend_q & SR_NV_MASK;
        end
    end

    always_comb begin
        if (busy_all) status_byte = 8'hFF;
        else begin
            status_byte          = nv_q & SR_NV_MASK;
            status_byte[BIT_WEL] = wel_q;
        end
    end
endmodule

// File: rtl/blkprot_status_chk.sv
module blkprot_status_chk
    import blkprot_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wp_pin,
    input logic       cyc_active,
    input logic       busy_all,
    input logic       sr_accept,
    input logic       wel_q,
    input logic       lock_on,
    input logic [7:0] status_byte,
    input logic       arr_wr_ok,
    input logic       sr_wr_ok
);
    a_r2_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_active |-> status_byte == 8'hFF);

    a_r6_wel_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_active) |-> !wel_q);

    a_r4_arr_needs_wel_wp: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> (wel_q && wp_pin));

    a_r5_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |-> !sr_wr_ok);

    a_r9_busy_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
        busy_all |-> (!arr_wr_ok && !sr_wr_ok));

    a_r7_set_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(wp_pin));

    a_r8_sr_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sr_accept |=> cyc_active);
endmodule

bind blkprot_status blkprot_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_pin      (wp_pin),
    .cyc_active  (cyc_active),
    .busy_all    (busy_all),
    .sr_accept   (sr_accept),
    .wel_q       (wel_q),
    .lock_on     (lock_on),
    .status_byte (status_byte),
    .arr_wr_ok   (arr_wr_ok),
    .sr_wr_ok    (sr_wr_ok)
);

// File: tb/blkprot_status_test.sv
module blkprot_status_test;
    localparam int ADDR_W = 15;
    localparam int SRC    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_pin = 1'b1, wel_set = 1'b0, wel_clr = 1'b0, sr_wr_req = 1'b0;
    logic [7:0] sr_wr_data = 8'h00;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic eng_busy = 1'b0, eng_done = 1'b0;
    logic [7:0] status_byte;
    logic arr_wr_ok, sr_wr_ok;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_wel, m_lock_en, m_lvl, m_mode, m_cnt, m_pend;

    always #5 clk = ~clk;

    blkprot_status #(.ADDR_W(ADDR_W), .SR_PROG_CYC(SRC)) uut (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wel_set(wel_set),
        .wel_clr(wel_clr), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
        .chk_addr(chk_addr), .eng_busy(eng_busy), .eng_done(eng_done),
        .status_byte(status_byte), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    function automatic bit m_busy();
        return (m_mode != 0) || eng_busy;
    endfunction

    function automatic bit m_prot(int a);
        int size = 1 << ADDR_W;
        case (m_lvl)
            0: return 0;
            1: return a >= (size / 4) * 3;
            2: return a >= size / 2;
            default: return 1;
        endcase
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int n_wel = m_wel;
        bit sr_ok;
        if (m_mode == 1) begin
            if (m_cnt == SRC - 1) begin
                m_mode = 0; n_wel = 0;
                m_lock_en = (m_pend >> 7) & 1;
                m_lvl = (m_pend >> 2) & 3;
            end else m_cnt++;
        end else if (m_mode == 2) begin
            if (eng_done) begin m_mode = 0; n_wel = 0; end
        end else if (eng_busy) begin
            m_mode = 2;
        end else begin
            sr_ok = (m_wel == 1) && !(m_lock_en == 1 && !wp_pin);
            if (sr_wr_req && sr_ok) begin
                m_pend = sr_wr_data; m_mode = 1; m_cnt = 0;
            end
            if (wel_clr) n_wel = 0;
            else if (wel_set && wp_pin) n_wel = 1;
        end
        m_wel = n_wel;
    endtask

    task automatic step(string tag);
        int exp_sr, exp_arr, exp_st;
        #1;
        if (m_busy()) exp_st = 8'hFF;
        else exp_st = (m_lock_en << 7) | (m_lvl << 2) | (m_wel << 1);
        exp_sr  = !m_busy() && m_wel == 1 && !(m_lock_en == 1 && !wp_pin);
        exp_arr = !m_busy() && m_wel == 1 && wp_pin && !m_prot(int'(chk_addr));
        cmp(tag, "status_byte", int'(status_byte), exp_st);
        cmp(tag, "sr_wr_ok", int'(sr_wr_ok), exp_sr);
        cmp(tag, "arr_wr_ok", int'(arr_wr_ok), exp_arr);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wel_set = 0; wel_clr = 0; sr_wr_req = 0; eng_done = 0;
    endtask

    task automatic sr_program(logic [7:0] d);
        wp_pin = 1; wel_set = 1; step("R7");
        sr_wr_req = 1; sr_wr_data = d; step("R8");
        for (int i = 0; i < SRC; i++) step("R2");
        step("R8");
    endtask

    task automatic sweep(string tag);
        logic [ADDR_W-1:0] pts [6];
        pts = '{15'h0000, 15'h3FFF, 15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF};
        for (int i = 0; i < 6; i++) begin
            chk_addr = pts[i];
            step(tag);
        end
    endtask

    initial begin
        m_wel = 0; m_lock_en = 0; m_lvl = 0; m_mode = 0; m_cnt = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R6");                          // reset state
        // R7: set refused with pin low
        wp_pin = 0; wel_set = 1; step("R7");
        step("R7");
        // R7 / R1: set with pin high, layout shows latch
        wp_pin = 1; wel_set = 1; step("R7");
        step("R1");
        // R7: both strobes together, clear wins
        wel_set = 1; wel_clr = 1; step("R7");
        step("R7");
        // R8: status write with junk bits, lock-enable and full protection
        sr_program(8'hFF);
        step("R1");
        wel_set = 1; step("R7");
        sweep("R3");
        // R5: lock active with pin low
        wp_pin = 0; step("R5");
        // R10: status write refused under lock
        sr_wr_req = 1; sr_wr_data = 8'h00; step("R10");
        step("R10");
        step("R10");
        // R4: array write refused with pin low
        chk_addr = 15'h0010; step("R4");
        // clear protection with pin high
        sr_program(8'h04);                   // level 01, lock off
        wel_set = 1; step("R7");
        sweep("R3");
        wp_pin = 0; step("R4");
        step("R5");
        wp_pin = 1;
        sr_program(8'h08);                   // level 10
        wel_set = 1; step("R7");
        sweep("R3");
        sr_program(8'h00);                   // level 00
        wel_set = 1; step("R7");
        sweep("R3");
        // R9: engine cycle, strobes ignored, done clears latch
        chk_addr = 15'h0100;
        eng_busy = 1; step("R2");
        wel_clr = 1; step("R9");
        sr_wr_req = 1; sr_wr_data = 8'h8C; step("R9");
        wel_set = 1; wel_clr = 1; sr_wr_req = 1; eng_done = 1; step("R6");
        eng_busy = 0; step("R6");
        step("R9");
        // R10: status write with latch clear
        sr_wr_req = 1; sr_wr_data = 8'h8C; step("R10");
        step("R10");
        // R8: bits 6..4,1,0 of data not stored
        sr_program(8'h73);
        step("R8");
        report();
    end
endmodule